// File: doc/BRIEF.md
# Transfer Address Protection Checker

This block sits beside a transfer engine and judges every memory access it makes against one or two programmed address windows. Each access arrives with an address, a write flag and a 4-bit packet number. The block flags accesses that fall outside the permitted space under the active access-rights rule. On such a violation it sets a sticky flag for the active mode and captures the packet number of the first offender. When interrupts are enabled for the active mode, it also pulses an error line toward an error-collection unit.

Software programs the block through a small register port. The port holds a control word, inclusive lower and upper bounds for two windows, and a status word. The status word shows the two flags, the captured packet number and a held bit. Flags are cleared by writing 1 to them.

Capture is handled by a two-state machine. In `CAP_OPEN` nothing is frozen, and the first violation moves it to `CAP_HELD` while storing the packet number. In `CAP_HELD` later violations are ignored. A status read with debug mode low moves it back to `CAP_OPEN`. A status read with debug mode high leaves it in `CAP_HELD`.

Top module: `xfer_addr_guard`

Register select codes are: 0 control, 1 window-0 low, 2 window-0 high, 3 window-1 low, 4 window-1 high, 5 status. The other select codes read 0.

The control word uses these bits, and all others are reserved:
- single-window mode: bit 0 enable, bit 1 deny-all, bit 2 interrupt enable;
- dual-window mode: bit 4 enable, bit 5 deny-all, bit 6 interrupt enable.

The status word uses these bits:
- bit 0: single-window flag;
- bit 1: dual-window flag;
- bits 11:8: captured packet number;
- bit 15: held.

## Requirements
- R1: After reset, every register reads 0, the machine is in `CAP_OPEN` and `err_pulse` is 0.
- R2: In single-window mode (control bit 0 set, bit 4 clear), an access whose address lies between the window-0 bounds, both bounds included, is never a violation.
- R3: Outside the permitted space, a deny-all bit of 0 lets reads through and flags writes, and a deny-all bit of 1 flags every access. Bit 1 applies to single-window mode and bit 5 to dual-window mode.
- R4: In dual-window mode (control bit 4), an access inside window 0 or window 1 is permitted. A forbidden access outside both sets the dual flag (status bit 1); a single-window violation sets status bit 0.
- R5: When both enables are set, dual-window mode governs. When neither is set, no access is a violation.
- R6: In `CAP_OPEN`, a violation captures its packet number into status bits 11:8 and enters `CAP_HELD`. In `CAP_HELD`, later violations leave the number unchanged until a status read taken with `dbg_mode` low.
- R7: A status read taken while `dbg_mode` is high leaves the machine in `CAP_HELD` and keeps the captured number.
- R8: `err_pulse` is high for exactly the one cycle after a violating access, and only if the interrupt-enable bit of the active mode is set (bit 2 single, bit 6 dual).
- R9: Writing 1 to status bit 0 or bit 1 clears that flag, and a violation in the same cycle wins. Reserved control and status bits read 0 and ignore writes.
- R10: Each window bound register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe from the transfer engine |
| acc_addr | input | AW | Access address |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_pkt | input | 4 | Control-packet number of the access |
| dbg_mode | input | 1 | Debug mode; keeps the capture frozen across status reads |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| err_pulse | output | 1 | One-cycle error pulse toward the error collector |

## Verification
A wrong capture state shows on the status word at the next status read. A machine stuck in `CAP_HELD` keeps an old packet number after a release read. A machine that drops out of `CAP_HELD` on a debug read shows a new number after the next violation. A wrong verdict shows on `err_pulse` exactly one cycle after the access, and on the flag bits at the next read. The bench's cycle model therefore compares `err_pulse` on every clock and the full register word on every read.

// File: rtl/xag_pkg.sv
`timescale 1ns/1ps
package xag_pkg;
    localparam int SEL_W   = 3;
    localparam int NWIN    = 2;
    localparam int PKT_W   = 4;
    localparam int REG_W   = 32;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 3'd0,
        SEL_LO0  = 3'd1,
        SEL_HI0  = 3'd2,
        SEL_LO1  = 3'd3,
        SEL_HI1  = 3'd4,
        SEL_STAT = 3'd5
    } xag_sel_e;

    typedef struct packed {
        logic dw_irq;
        logic dw_deny;
        logic dw_en;
        logic sw_irq;
        logic sw_deny;
        logic sw_en;
    } xag_ctrl_t;

    typedef enum logic {
        CAP_OPEN = 1'b0,
        CAP_HELD = 1'b1
    } cap_state_e;
endpackage

// File: rtl/xag_regs.sv
`timescale 1ns/1ps
module xag_regs
    import xag_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [SEL_W-1:0]         reg_sel,
    input  logic [REG_W-1:0]         reg_wdata,
    output xag_ctrl_t                ctrl_q,
    output logic [NWIN-1:0][AW-1:0]  lo_q,
    output logic [NWIN-1:0][AW-1:0]  hi_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr && reg_sel == SEL_CTRL) begin
            ctrl_q.sw_en   <= reg_wdata[0];
            ctrl_q.sw_deny <= reg_wdata[1];
            ctrl_q.sw_irq  <= reg_wdata[2];
            ctrl_q.dw_en   <= reg_wdata[4];
            ctrl_q.dw_deny <= reg_wdata[5];
            ctrl_q.dw_irq  <= reg_wdata[6];
        end
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam logic [SEL_W-1:0] LO_SEL = SEL_W'(1 + 2 * w);
        localparam logic [SEL_W-1:0] HI_SEL = SEL_W'(2 + 2 * w);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[w] <= '0;
                hi_q[w] <= '0;
            end else if (reg_wr) begin
                if (reg_sel == LO_SEL) lo_q[w] <= reg_wdata[AW-1:0];
                if (reg_sel == HI_SEL) hi_q[w] <= reg_wdata[AW-1:0];
            end
        end
    end
endmodule

// File: rtl/xag_window.sv
`timescale 1ns/1ps
module xag_window
    import xag_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_valid,
    input  logic [AW-1:0]            acc_addr,
    input  logic                     acc_write,
    input  xag_ctrl_t                ctrl,
    input  logic [NWIN-1:0][AW-1:0]  lo,
    input  logic [NWIN-1:0][AW-1:0]  hi,
    output logic                     viol,
    output logic                     viol_dual
);
    logic [NWIN-1:0] in_win;

    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        assign in_win[w] = (acc_addr >= lo[w]) && (acc_addr <= hi[w]);
    end

    logic outside;
    logic deny;
    always_comb begin
        viol_dual = 1'b0;
        outside   = 1'b0;
        deny      = 1'b0;
        if (ctrl.dw_en) begin
            viol_dual = 1'b1;
            outside   = ~|in_win;
            deny      = ctrl.dw_deny;
        end else if (ctrl.sw_en) begin
            outside   = ~in_win[0];
            deny      = ctrl.sw_deny;
        end
        viol = acc_valid && outside && (deny || acc_write);
    end

    a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.sw_en && !ctrl.dw_en) |-> !viol);

    a_r2_inside0_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.sw_en && !ctrl.dw_en && acc_addr >= lo[0] && acc_addr <= hi[0]) |-> !viol);

    a_r3_read_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_write && !ctrl.dw_en && !ctrl.sw_deny) |-> !viol);
endmodule

// File: rtl/xag_capture.sv
`timescale 1ns/1ps
module xag_capture
    import xag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              viol,
    input  logic              viol_dual,
    input  logic              irq_en,
    input  logic [PKT_W-1:0]  acc_pkt,
    input  logic              stat_rd,
    input  logic              dbg_mode,
    input  logic              clr_sw,
    input  logic              clr_dw,
    output logic              sw_flag_q,
    output logic              dw_flag_q,
    output logic [PKT_W-1:0]  pkt_q,
    output logic              held,
    output logic              err_pulse
);
    cap_state_e state_q, state_d;
    logic       load_pkt;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAP_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        load_pkt = 1'b0;
        unique case (state_q)
            CAP_OPEN: begin
                if (viol) begin
                    state_d  = CAP_HELD;
                    load_pkt = 1'b1;
                end
            end
            CAP_HELD: begin
                if (stat_rd && !dbg_mode) state_d = CAP_OPEN;
            end
            default: state_d = CAP_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_q     <= '0;
            sw_flag_q <= 1'b0;
            dw_flag_q <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            if (load_pkt) pkt_q <= acc_pkt;
            sw_flag_q <= (sw_flag_q && !clr_sw) || (viol && !viol_dual);
            dw_flag_q <= (dw_flag_q && !clr_dw) || (viol && viol_dual);
            err_pulse <= viol && irq_en;
        end
    end

    assign held = (state_q == CAP_HELD);

    a_r6_hold_pkt: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_HELD && !(stat_rd && !dbg_mode)) |=> ($stable(pkt_q) && state_q == CAP_HELD));

    a_r6_capture_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_OPEN && viol) |=> (state_q == CAP_HELD && pkt_q == $past(acc_pkt)));

    a_r7_dbg_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_HELD && dbg_mode) |=> state_q == CAP_HELD);

    a_r8_err_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (sw_flag_q || dw_flag_q));
endmodule

// File: rtl/xfer_addr_guard.sv
`timescale 1ns/1ps
module xfer_addr_guard
    import xag_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [AW-1:0]     acc_addr,
    input  logic              acc_write,
    input  logic [3:0]        acc_pkt,
    input  logic              dbg_mode,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              err_pulse
);
    xag_ctrl_t                ctrl_q;
    logic [NWIN-1:0][AW-1:0]  lo_q, hi_q;
    logic                     viol, viol_dual;
    logic                     sw_flag, dw_flag, held;
    logic [PKT_W-1:0]         pkt_q;

    wire stat_sel = (reg_sel == SEL_STAT);
    wire irq_en   = ctrl_q.dw_en ? ctrl_q.dw_irq : ctrl_q.sw_irq;

    xag_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_q(ctrl_q), .lo_q(lo_q), .hi_q(hi_q)
    );

    xag_window #(.AW(AW)) u_window (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .ctrl(ctrl_q), .lo(lo_q), .hi(hi_q),
        .viol(viol), .viol_dual(viol_dual)
    );

    xag_capture u_capture (
        .clk(clk), .rst_n(rst_n), .viol(viol), .viol_dual(viol_dual),
        .irq_en(irq_en), .acc_pkt(acc_pkt), .stat_rd(reg_rd && stat_sel),
        .dbg_mode(dbg_mode), .clr_sw(reg_wr && stat_sel && reg_wdata[0]),
        .clr_dw(reg_wr && stat_sel && reg_wdata[1]), .sw_flag_q(sw_flag),
        .dw_flag_q(dw_flag), .pkt_q(pkt_q), .held(held), .err_pulse(err_pulse)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL: reg_rdata = {25'd0, ctrl_q.dw_irq, ctrl_q.dw_deny, ctrl_q.dw_en,
                                   1'b0, ctrl_q.sw_irq, ctrl_q.sw_deny, ctrl_q.sw_en};
            SEL_LO0:  reg_rdata = 32'(lo_q[0]);
            SEL_HI0:  reg_rdata = 32'(hi_q[0]);
            SEL_LO1:  reg_rdata = 32'(lo_q[1]);
            SEL_HI1:  reg_rdata = 32'(hi_q[1]);
            SEL_STAT: reg_rdata = {16'd0, held, 3'd0, pkt_q, 6'd0, dw_flag, sw_flag};
            default:  reg_rdata = '0;
        endcase
    end

    a_r1_quiet_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !err_pulse);
endmodule

// File: tb/xfer_addr_guard_bench.sv
`timescale 1ns/1ps
module xfer_addr_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_pkt = '0;
    logic        dbg_mode = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        err_pulse;

    always #2.5 clk = ~clk;

    xfer_addr_guard u_xfer_addr_guard (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_pkt(acc_pkt), .dbg_mode(dbg_mode),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_pulse(err_pulse)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    logic [31:0] m_ctrl = 0, m_lo0 = 0, m_hi0 = 0, m_lo1 = 0, m_hi1 = 0;
    bit          m_swf = 0, m_dwf = 0, m_held = 0, m_err = 0;
    logic [3:0]  m_pkt = 0;

    function automatic logic [31:0] m_read(input logic [2:0] s);
        case (s)
            3'd0: return m_ctrl;
            3'd1: return m_lo0;
            3'd2: return m_hi0;
            3'd3: return m_lo1;
            3'd4: return m_hi1;
            3'd5: return {16'd0, m_held, 3'd0, m_pkt, 6'd0, m_dwf, m_swf};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive, compare read data, predict, compare err_pulse
    task automatic cycle(input bit v, input logic [31:0] a, input bit w, input logic [3:0] p,
                         input bit rw, input bit rr, input logic [2:0] s,
                         input logic [31:0] d, input bit dbg, input string tag);
        bit in0, in1, bad, dual, irq;
        acc_valid = v; acc_addr = a; acc_write = w; acc_pkt = p;
        reg_wr = rw; reg_rd = rr; reg_sel = s; reg_wdata = d; dbg_mode = dbg;
        #1;
        if (rr) chk(tag, reg_rdata, m_read(s));
        in0  = (a >= m_lo0) && (a <= m_hi0);
        in1  = (a >= m_lo1) && (a <= m_hi1);
        dual = m_ctrl[4];
        bad  = 0;
        if (dual)           bad = v && !(in0 || in1) && (m_ctrl[5] || w);
        else if (m_ctrl[0]) bad = v && !in0 && (m_ctrl[1] || w);
        irq = dual ? m_ctrl[6] : m_ctrl[2];
        @(posedge clk);
        m_err = bad && irq;
        if (rw && s == 3'd5) begin
            if (d[0]) m_swf = 0;
            if (d[1]) m_dwf = 0;
        end
        if (bad && dual)  m_dwf = 1;
        if (bad && !dual) m_swf = 1;
        if (m_held) begin
            if (rr && s == 3'd5 && !dbg) m_held = 0;
        end else if (bad) begin
            m_held = 1;
            m_pkt  = p;
        end
        if (rw) case (s)
            3'd0: m_ctrl = d & 32'h77;
            3'd1: m_lo0 = d;
            3'd2: m_hi0 = d;
            3'd3: m_lo1 = d;
            3'd4: m_hi1 = d;
            default: ;
        endcase
        @(negedge clk);
        chk({tag, " err_pulse"}, {31'd0, err_pulse}, {31'd0, m_err});
        acc_valid = 0; reg_wr = 0; reg_rd = 0; dbg_mode = 0;
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d, input string tag);
        cycle(0, 0, 0, 0, 1, 0, s, d, 0, tag);
    endtask
    task automatic rd(input logic [2:0] s, input bit dbg, input string tag);
        cycle(0, 0, 0, 0, 0, 1, s, 0, dbg, tag);
    endtask
    task automatic acc(input logic [31:0] a, input bit w, input logic [3:0] p, input string tag);
        cycle(1, a, w, p, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 err at reset", {31'd0, err_pulse}, 32'd0);
        rst_n = 1'b1;
        for (int s = 0; s < 8; s++) rd(3'(s), 0, "R1 reset read");

        // single-window setup
        wr(3'd1, 32'h0000_1000, "R10");
        wr(3'd2, 32'h0000_1FFF, "R10");
        wr(3'd0, 32'h0000_0005, "R10");
        rd(3'd1, 0, "R10 lo0");
        rd(3'd2, 0, "R10 hi0");
        rd(3'd0, 0, "R9 ctrl");
        acc(32'h0000_0800, 0, 4'h1, "R3 read outside allowed");
        acc(32'h0000_1000, 1, 4'h2, "R2 low bound");
        acc(32'h0000_1FFF, 1, 4'h2, "R2 high bound");
        acc(32'h0000_2000, 1, 4'h3, "R8 write outside");
        rd(3'd5, 1, "R6 captured under debug");
        acc(32'h0000_3000, 1, 4'h9, "R6 second violation");
        rd(3'd5, 1, "R7 debug read keeps number");
        acc(32'h0000_0000, 1, 4'h5, "R7 violation after debug read");
        rd(3'd5, 0, "R7 still frozen");
        rd(3'd5, 0, "R6 released");
        acc(32'h0000_2100, 1, 4'h6, "R6 new capture");
        rd(3'd5, 0, "R6 new packet");

        // flags and reserved bits
        wr(3'd5, 32'hFFFF_FFFF, "R9 clear");
        rd(3'd5, 0, "R9 flags cleared");
        wr(3'd3, 32'h0000_4000, "R10");
        wr(3'd4, 32'h0000_4FFF, "R10");
        rd(3'd3, 0, "R10 lo1");
        rd(3'd4, 0, "R10 hi1");
        wr(3'd0, 32'hFFFF_FFFF, "R9 reserved");
        rd(3'd0, 0, "R9 reserved ctrl");

        // dual mode precedence, deny all, irq on
        acc(32'h0000_4800, 0, 4'hA, "R4 inside window 1");
        acc(32'h0000_1800, 1, 4'hA, "R4 inside window 0");
        acc(32'h0000_3000, 0, 4'hB, "R5 dual governs read");
        rd(3'd5, 0, "R4 dual flag");
        // dual, reads allowed, irq off
        wr(3'd5, 32'h3, "R9");
        wr(3'd0, 32'h0000_0010, "R8 irq off");
        acc(32'h0000_5000, 0, 4'hC, "R3 dual read allowed");
        acc(32'h0000_5000, 1, 4'hD, "R8 no pulse when disabled");
        rd(3'd5, 0, "R4 flag without pulse");
        // violation wins over clear in same cycle
        cycle(1, 32'h0000_6000, 1, 4'hE, 1, 0, 3'd5, 32'h3, 0, "R9 set beats clear");
        rd(3'd5, 0, "R9 set beats clear read");
        // both off
        wr(3'd5, 32'h3, "R9");
        wr(3'd0, 32'h0, "R5");
        acc(32'hFFFF_FFFF, 1, 4'h7, "R5 disabled");
        rd(3'd5, 0, "R5 no flag");
        // single deny all
        wr(3'd0, 32'h0000_0003, "R3");
        acc(32'h0000_0010, 0, 4'h8, "R3 deny all read");
        rd(3'd5, 0, "R3 flagged read");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule